// File: doc/BRIEF.md
# Two-Slot Execute Stage with Bypass and Branch Arbitration

This block is the execute stage of a two-wide in-order pipeline. Each cycle it takes a pair of decoded instructions (slot 0 is the older one, slot 1 the younger), each with its register indices, register-file values, immediate and program counter. It computes both results in parallel, one ALU per slot, and registers them as two write-back records for the load-store stage. It also registers a single redirect request when a branch in the pair is taken.

Each source operand can be replaced by a newer value before it reaches its ALU. There are four candidate sources. Two are this stage's own registered records, which belong to the previous pair. The other two are the write-back records coming back from the load-store stage. The choice among them is a fixed priority, described here as named selections:
- SRC_EX1 is the previous pair's slot 1.
- SRC_EX0 is the previous pair's slot 0.
- SRC_LS1 is load-store slot 1.
- SRC_LS0 is load-store slot 0.
- SRC_RF is the decoded register value, used when none of the others match.

The redirect arbiter has three outcomes:
- RD_NONE: no branch is taken.
- RD_SLOT0: slot 0 is taken. This also cancels slot 1.
- RD_SLOT1: slot 1 is taken and slot 0 is not.

The decode stage is expected to keep dependent instructions out of the same pair. For that reason there is no bypass from slot 0 into slot 1 within a pair.

Top module: `dx_exec_pair`

## Requirements
- R1: While rst_n is low, out_valid, out_wen and br_req are all zero.
- R2: A valid slot with an ALU opcode writes its result to out_data one clock edge after the inputs are presented, with out_valid=1, out_wen=1 and out_rd equal to its destination. The opcodes are 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 shift left by B[4:0], 6 logical shift right by B[4:0], and 7 set-if-less-than signed, which gives 1 or 0.
- R3: When in_use_imm is 1 for a slot, its ALU second operand is the immediate rather than operand B.
- R4: Opcodes 8 (branch if A==B), 9 (branch if A!=B), 10 (branch if A<B signed) and 11 (unconditional jump) never write back, and they report out_valid=1. A taken branch raises br_req one edge later with br_target = pc + imm. br_req stays low when no valid branch is taken.
- R5: A slot with in_valid=0 gives out_valid=0 and out_wen=0, and it takes no part in redirection.
- R6: A source index that matches a write-back record of the previous pair held in this stage (out_wen=1, same out_rd) takes that record's data. This applies to operand A and operand B of both slots, and it wins over any load-store record.
- R7: When both records of the same stage match, the slot-1 record wins. This holds for the execute records and for the load-store records.
- R8: With no execute-stage match, a source takes the data of a load-store record with ls_valid=1 and the same ls_rd. A record with ls_valid=0 is ignored.
- R9: A taken branch in slot 0 redirects to its own target and cancels slot 1. The cancelled slot gives out_valid=0 and out_wen=0, its branch is ignored, and its result is never forwarded.
- R10: A taken branch in slot 1 redirects only when slot 0 is invalid or is not a taken branch.
- R11: Opcodes 12 to 15 give out_valid=1 with no write-back and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-slot instruction present (0 = bubble) |
| in_op | input | 2x4 | Per-slot opcode |
| in_rd | input | 2xAW | Per-slot destination index |
| in_ra | input | 2xAW | Per-slot operand A index |
| in_rb | input | 2xAW | Per-slot operand B index |
| in_va | input | 2xXLEN | Per-slot operand A register-file value |
| in_vb | input | 2xXLEN | Per-slot operand B register-file value |
| in_imm | input | 2xXLEN | Per-slot immediate / branch offset |
| in_use_imm | input | 2 | Per-slot: ALU second operand is the immediate |
| in_pc | input | 2xXLEN | Per-slot program counter |
| ls_valid | input | 2 | Load-store stage write-back valid, per slot |
| ls_rd | input | 2xAW | Load-store stage write-back index |
| ls_data | input | 2xXLEN | Load-store stage write-back data |
| out_valid | output | 2 | Per-slot record valid |
| out_wen | output | 2 | Per-slot register write enable |
| out_rd | output | 2xAW | Per-slot destination index |
| out_data | output | 2xXLEN | Per-slot result |
| br_req | output | 1 | Redirect request |
| br_target | output | XLEN | Redirect target |

## Verification
Two functions can coincide in the same cycle. The first is forwarding from this stage's own records while a load-store record names the same register. The bench provokes this with back-to-back dependent pairs, with both slots writing one index and a load-store record for that index driven at the same time, and it judges that the newest slot-1 value arrives. The second is a pair in which both slots hold branches, or a taken slot 0 beside a writing slot 1. Here the bench checks that exactly the slot-0 target appears, that slot 1 is silent, and that the following pair does not see the cancelled result through forwarding.

// File: rtl/dx_pkg.sv
package dx_pkg;

    localparam int NSLOT = 2;
    localparam int OPW   = 4;

    localparam logic [OPW-1:0] OP_ADD = 4'd0;
    localparam logic [OPW-1:0] OP_SUB = 4'd1;
    localparam logic [OPW-1:0] OP_AND = 4'd2;
    localparam logic [OPW-1:0] OP_OR  = 4'd3;
    localparam logic [OPW-1:0] OP_XOR = 4'd4;
    localparam logic [OPW-1:0] OP_SLL = 4'd5;
    localparam logic [OPW-1:0] OP_SRL = 4'd6;
    localparam logic [OPW-1:0] OP_SLT = 4'd7;
    localparam logic [OPW-1:0] OP_BEQ = 4'd8;
    localparam logic [OPW-1:0] OP_BNE = 4'd9;
    localparam logic [OPW-1:0] OP_BLT = 4'd10;
    localparam logic [OPW-1:0] OP_JMP = 4'd11;

    typedef enum logic [2:0] {
        SRC_EX1,
        SRC_EX0,
        SRC_LS1,
        SRC_LS0,
        SRC_RF
    } fwd_src_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_SLOT0,
        RD_SLOT1
    } redirect_e;

endpackage

// File: rtl/dx_fwd_mux.sv
module dx_fwd_mux
    import dx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]              src_idx,
    input  logic [XLEN-1:0]            rf_val,
    input  logic [NSLOT-1:0]           ex_wen,
    input  logic [NSLOT-1:0][AW-1:0]   ex_rd,
    input  logic [NSLOT-1:0][XLEN-1:0] ex_data,
    input  logic [NSLOT-1:0]           ls_valid,
    input  logic [NSLOT-1:0][AW-1:0]   ls_rd,
    input  logic [NSLOT-1:0][XLEN-1:0] ls_data,
    output logic [XLEN-1:0]            val
);

    fwd_src_e sel;

    // newest producer first: execute before load-store, slot 1 before slot 0
    always_comb begin
        if (ex_wen[1] && (ex_rd[1] == src_idx))
            sel = SRC_EX1;
        else if (ex_wen[0] && (ex_rd[0] == src_idx))
            sel = SRC_EX0;
        else if (ls_valid[1] && (ls_rd[1] == src_idx))
            sel = SRC_LS1;
        else if (ls_valid[0] && (ls_rd[0] == src_idx))
            sel = SRC_LS0;
        else
            sel = SRC_RF;
    end

    always_comb begin
        unique case (sel)
            SRC_EX1: val = ex_data[1];
            SRC_EX0: val = ex_data[0];
            SRC_LS1: val = ls_data[1];
            SRC_LS0: val = ls_data[0];
            default: val = rf_val;
        endcase
    end

endmodule

// File: rtl/dx_alu.sv
module dx_alu
    import dx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] imm,
    input  logic            use_imm,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] result,
    output logic            wen,
    output logic            taken,
    output logic [XLEN-1:0] target
);

    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] b_eff;
    logic [SHW-1:0]  shamt;
    logic            lt_s;

    assign b_eff  = use_imm ? imm : opb;
    assign shamt  = b_eff[SHW-1:0];
    assign lt_s   = $signed(opa) < $signed(opb);
    assign target = pc + imm;

    always_comb begin
        result = '0;
        wen    = 1'b0;
        taken  = 1'b0;
        unique case (op)
            OP_ADD: begin result = opa + b_eff;   wen = 1'b1; end
            OP_SUB: begin result = opa - b_eff;   wen = 1'b1; end
            OP_AND: begin result = opa & b_eff;   wen = 1'b1; end
            OP_OR:  begin result = opa | b_eff;   wen = 1'b1; end
            OP_XOR: begin result = opa ^ b_eff;   wen = 1'b1; end
            OP_SLL: begin result = opa << shamt;  wen = 1'b1; end
            OP_SRL: begin result = opa >> shamt;  wen = 1'b1; end
            OP_SLT: begin
                result = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(b_eff))};
                wen    = 1'b1;
            end
            OP_BEQ: taken = (opa == opb);
            OP_BNE: taken = (opa != opb);
            OP_BLT: taken = lt_s;
            OP_JMP: taken = 1'b1;
            default: begin
                result = '0;
                wen    = 1'b0;
                taken  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dx_br_arb.sv
module dx_br_arb
    import dx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [NSLOT-1:0]           slot_valid,
    input  logic [NSLOT-1:0]           slot_taken,
    input  logic [NSLOT-1:0][XLEN-1:0] slot_target,
    output logic                       redirect,
    output logic [XLEN-1:0]            redirect_pc,
    output logic                       kill_young
);

    redirect_e choice;

    always_comb begin
        if (slot_valid[0] && slot_taken[0])
            choice = RD_SLOT0;
        else if (slot_valid[1] && slot_taken[1])
            choice = RD_SLOT1;
        else
            choice = RD_NONE;
    end

    always_comb begin
        unique case (choice)
            RD_SLOT0: begin
                redirect    = 1'b1;
                redirect_pc = slot_target[0];
                kill_young  = 1'b1;
            end
            RD_SLOT1: begin
                redirect    = 1'b1;
                redirect_pc = slot_target[1];
                kill_young  = 1'b0;
            end
            default: begin
                redirect    = 1'b0;
                redirect_pc = '0;
                kill_young  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dx_exec_pair.sv
module dx_exec_pair
    import dx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSLOT-1:0]           in_valid,
    input  logic [NSLOT-1:0][OPW-1:0]  in_op,
    input  logic [NSLOT-1:0][AW-1:0]   in_rd,
    input  logic [NSLOT-1:0][AW-1:0]   in_ra,
    input  logic [NSLOT-1:0][AW-1:0]   in_rb,
    input  logic [NSLOT-1:0][XLEN-1:0] in_va,
    input  logic [NSLOT-1:0][XLEN-1:0] in_vb,
    input  logic [NSLOT-1:0][XLEN-1:0] in_imm,
    input  logic [NSLOT-1:0]           in_use_imm,
    input  logic [NSLOT-1:0][XLEN-1:0] in_pc,
    input  logic [NSLOT-1:0]           ls_valid,
    input  logic [NSLOT-1:0][AW-1:0]   ls_rd,
    input  logic [NSLOT-1:0][XLEN-1:0] ls_data,
    output logic [NSLOT-1:0]           out_valid,
    output logic [NSLOT-1:0]           out_wen,
    output logic [NSLOT-1:0][AW-1:0]   out_rd,
    output logic [NSLOT-1:0][XLEN-1:0] out_data,
    output logic                       br_req,
    output logic [XLEN-1:0]            br_target
);

    logic [NSLOT-1:0][XLEN-1:0] opa;
    logic [NSLOT-1:0][XLEN-1:0] opb;
    logic [NSLOT-1:0][XLEN-1:0] alu_res;
    logic [NSLOT-1:0]           alu_wen;
    logic [NSLOT-1:0]           alu_taken;
    logic [NSLOT-1:0][XLEN-1:0] alu_tgt;

    logic                       redir_c;
    logic [XLEN-1:0]            redir_pc_c;
    logic                       kill1;
    logic [NSLOT-1:0]           valid_n;
    logic [NSLOT-1:0]           wen_n;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dx_fwd_mux #(.XLEN(XLEN), .AW(AW)) u_fwd_a (
            .src_idx (in_ra[s]),
            .rf_val  (in_va[s]),
            .ex_wen  (out_wen),
            .ex_rd   (out_rd),
            .ex_data (out_data),
            .ls_valid(ls_valid),
            .ls_rd   (ls_rd),
            .ls_data (ls_data),
            .val     (opa[s])
        );

        dx_fwd_mux #(.XLEN(XLEN), .AW(AW)) u_fwd_b (
            .src_idx (in_rb[s]),
            .rf_val  (in_vb[s]),
            .ex_wen  (out_wen),
            .ex_rd   (out_rd),
            .ex_data (out_data),
            .ls_valid(ls_valid),
            .ls_rd   (ls_rd),
            .ls_data (ls_data),
            .val     (opb[s])
        );

        dx_alu #(.XLEN(XLEN)) u_alu (
            .op     (in_op[s]),
            .opa    (opa[s]),
            .opb    (opb[s]),
            .imm    (in_imm[s]),
            .use_imm(in_use_imm[s]),
            .pc     (in_pc[s]),
            .result (alu_res[s]),
            .wen    (alu_wen[s]),
            .taken  (alu_taken[s]),
            .target (alu_tgt[s])
        );
    end

    dx_br_arb #(.XLEN(XLEN)) u_arb (
        .slot_valid (in_valid),
        .slot_taken (alu_taken),
        .slot_target(alu_tgt),
        .redirect   (redir_c),
        .redirect_pc(redir_pc_c),
        .kill_young (kill1)
    );

    always_comb begin
        valid_n[0] = in_valid[0];
        valid_n[1] = in_valid[1] && !kill1;
        wen_n      = valid_n & alu_wen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_wen   <= '0;
            out_rd    <= '0;
            out_data  <= '0;
            br_req    <= 1'b0;
            br_target <= '0;
        end else begin
            out_valid <= valid_n;
            out_wen   <= wen_n;
            out_rd    <= in_rd;
            out_data  <= alu_res;
            br_req    <= redir_c;
            br_target <= redir_pc_c;
        end
    end

endmodule

// File: rtl/dx_exec_chk.sv
module dx_exec_chk
    import dx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSLOT-1:0]           in_valid,
    input logic [NSLOT-1:0][OPW-1:0]  in_op,
    input logic [NSLOT-1:0][AW-1:0]   in_ra,
    input logic [NSLOT-1:0][XLEN-1:0] in_imm,
    input logic [NSLOT-1:0]           in_use_imm,
    input logic [NSLOT-1:0][XLEN-1:0] in_pc,
    input logic [NSLOT-1:0]           ls_valid,
    input logic [NSLOT-1:0][AW-1:0]   ls_rd,
    input logic [NSLOT-1:0][XLEN-1:0] ls_data,
    input logic [NSLOT-1:0]           out_valid,
    input logic [NSLOT-1:0]           out_wen,
    input logic [NSLOT-1:0][AW-1:0]   out_rd,
    input logic [NSLOT-1:0][XLEN-1:0] out_data,
    input logic                       br_req,
    input logic [XLEN-1:0]            br_target
);

    logic move0;
    logic ex_hit0;
    logic br_in_pair;

    assign move0      = in_valid[0] && (in_op[0] == OP_OR) && in_use_imm[0] && (in_imm[0] == '0);
    assign ex_hit0    = (out_wen[0] && (out_rd[0] == in_ra[0])) || (out_wen[1] && (out_rd[1] == in_ra[0]));
    assign br_in_pair = (in_valid[0] && (in_op[0][3:2] == 2'b10)) || (in_valid[1] && (in_op[1][3:2] == 2'b10));

    AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wen & ~out_valid) == '0); // R2

    AST_BUBBLE_SLOT0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[0] |=> (!out_valid[0] && !out_wen[0])); // R5

    AST_BUBBLE_SLOT1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[1] |=> (!out_valid[1] && !out_wen[1])); // R5

    AST_NO_BRANCH_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !br_in_pair |=> !br_req); // R4

    AST_SLOT0_JUMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && (in_op[0] == OP_JMP)) |=>
            (br_req && !out_valid[1] && !out_wen[1] && (br_target == $past(in_pc[0] + in_imm[0])))); // R9

    AST_EX1_FORWARD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (move0 && out_wen[1] && (out_rd[1] == in_ra[0])) |=> (out_data[0] == $past(out_data[1]))); // R6

    AST_LS1_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (move0 && !ex_hit0 && ls_valid[1] && (ls_rd[1] == in_ra[0])) |=> (out_data[0] == $past(ls_data[1]))); // R8

endmodule

bind dx_exec_pair dx_exec_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_ra     (in_ra),
    .in_imm    (in_imm),
    .in_use_imm(in_use_imm),
    .in_pc     (in_pc),
    .ls_valid  (ls_valid),
    .ls_rd     (ls_rd),
    .ls_data   (ls_data),
    .out_valid (out_valid),
    .out_wen   (out_wen),
    .out_rd    (out_rd),
    .out_data  (out_data),
    .br_req    (br_req),
    .br_target (br_target)
);

// File: tb/sim_dx_exec_pair.sv
module sim_dx_exec_pair;
    import dx_pkg::*;

    localparam int XLEN = 32;
    localparam int AW   = 5;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [NSLOT-1:0]           in_valid;
    logic [NSLOT-1:0][OPW-1:0]  in_op;
    logic [NSLOT-1:0][AW-1:0]   in_rd, in_ra, in_rb;
    logic [NSLOT-1:0][XLEN-1:0] in_va, in_vb, in_imm, in_pc;
    logic [NSLOT-1:0]           in_use_imm;
    logic [NSLOT-1:0]           ls_valid;
    logic [NSLOT-1:0][AW-1:0]   ls_rd;
    logic [NSLOT-1:0][XLEN-1:0] ls_data;
    logic [NSLOT-1:0]           out_valid, out_wen;
    logic [NSLOT-1:0][AW-1:0]   out_rd;
    logic [NSLOT-1:0][XLEN-1:0] out_data;
    logic                       br_req;
    logic [XLEN-1:0]            br_target;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    dx_exec_pair #(.XLEN(XLEN), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_op(in_op), .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb),
        .in_va(in_va), .in_vb(in_vb), .in_imm(in_imm), .in_use_imm(in_use_imm), .in_pc(in_pc),
        .ls_valid(ls_valid), .ls_rd(ls_rd), .ls_data(ls_data),
        .out_valid(out_valid), .out_wen(out_wen), .out_rd(out_rd), .out_data(out_data),
        .br_req(br_req), .br_target(br_target)
    );

    typedef struct packed {
        logic        v0; logic [3:0] op0; logic [31:0] a0; logic [31:0] b0; logic [31:0] i0; logic u0;
        logic        v1; logic [3:0] op1; logic [31:0] a1; logic [31:0] b1; logic [31:0] i1; logic u1;
        logic        ev0; logic ew0; logic [31:0] ed0;
        logic        ev1; logic ew1; logic [31:0] ed1;
        logic        ebr; logic [31:0] etgt;
    } vec_t;

    // slot 0: rd 3, ra 1, rb 2, pc 100; slot 1: rd 6, ra 4, rb 5, pc 101
    localparam vec_t VECS [13] = '{
        '{1'b1, 4'd0,  32'd5, 32'd7, 32'd0, 1'b0,  1'b1, 4'd1, 32'd10, 32'd3, 32'd0, 1'b0,
          1'b1, 1'b1, 32'd12, 1'b1, 1'b1, 32'd7, 1'b0, 32'd0},                     // R2 add/sub
        '{1'b1, 4'd2,  32'hF0F0, 32'hFF00, 32'd0, 1'b0,  1'b1, 4'd3, 32'h0F, 32'hF0, 32'd0, 1'b0,
          1'b1, 1'b1, 32'hF000, 1'b1, 1'b1, 32'hFF, 1'b0, 32'd0},                  // R2 and/or
        '{1'b1, 4'd4,  32'hFFFF, 32'h00FF, 32'd0, 1'b0,  1'b1, 4'd5, 32'd1, 32'd4, 32'd0, 1'b0,
          1'b1, 1'b1, 32'hFF00, 1'b1, 1'b1, 32'd16, 1'b0, 32'd0},                  // R2 xor/sll
        '{1'b1, 4'd6,  32'h80000000, 32'd31, 32'd0, 1'b0,  1'b1, 4'd7, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0,
          1'b1, 1'b1, 32'd1, 1'b1, 1'b1, 32'd1, 1'b0, 32'd0},                      // R2 srl/slt signed
        '{1'b1, 4'd0,  32'd10, 32'd999, 32'd5, 1'b1,  1'b1, 4'd1, 32'd3, 32'd77, 32'd5, 1'b1,
          1'b1, 1'b1, 32'd15, 1'b1, 1'b1, 32'hFFFFFFFE, 1'b0, 32'd0},              // R3 immediate
        '{1'b1, 4'd8,  32'd4, 32'd4, 32'd20, 1'b0,  1'b1, 4'd0, 32'd1, 32'd1, 32'd0, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, 32'd120},                    // R4 R9 beq taken
        '{1'b1, 4'd9,  32'd4, 32'd4, 32'd20, 1'b0,  1'b1, 4'd0, 32'd2, 32'd3, 32'd0, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b1, 1'b1, 32'd5, 1'b0, 32'd0},                      // R4 bne not taken
        '{1'b1, 4'd9,  32'd4, 32'd5, 32'hFFFFFFFC, 1'b0,  1'b1, 4'd11, 32'd0, 32'd0, 32'd40, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, 32'd96},                     // R9 both branch
        '{1'b1, 4'd8,  32'd1, 32'd2, 32'd50, 1'b0,  1'b1, 4'd10, 32'hFFFFFFFE, 32'd1, 32'd8, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd0, 1'b1, 32'd109},                    // R10 blt slot1
        '{1'b1, 4'd12, 32'd1, 32'd2, 32'd3, 1'b0,  1'b1, 4'd15, 32'd1, 32'd2, 32'd3, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd0, 1'b0, 32'd0},                      // R11 spare codes
        '{1'b1, 4'd10, 32'd5, 32'hFFFFFFFD, 32'd9, 1'b0,  1'b1, 4'd11, 32'd0, 32'd0, 32'd2, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b1, 1'b0, 32'd0, 1'b1, 32'd103},                    // R10 jmp slot1
        '{1'b0, 4'd11, 32'd0, 32'd0, 32'd30, 1'b0,  1'b1, 4'd0, 32'd6, 32'd1, 32'd0, 1'b0,
          1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 32'd7, 1'b0, 32'd0},                      // R5 bubble slot0
        '{1'b1, 4'd11, 32'd0, 32'd0, 32'd16, 1'b0,  1'b0, 4'd0, 32'd1, 32'd1, 32'd0, 1'b0,
          1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, 32'd116}                     // R5 bubble slot1
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input int s, input logic v, input logic [3:0] op, input logic [AW-1:0] rd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input logic [31:0] va,
                       input logic [31:0] vb, input logic [31:0] imm, input logic ui, input logic [31:0] pc);
        in_valid[s] = v;  in_op[s] = op;  in_rd[s] = rd;  in_ra[s] = ra;  in_rb[s] = rb;
        in_va[s] = va;    in_vb[s] = vb;  in_imm[s] = imm; in_use_imm[s] = ui; in_pc[s] = pc;
    endtask

    task automatic lsw(input int s, input logic v, input logic [AW-1:0] rd, input logic [31:0] d);
        ls_valid[s] = v; ls_rd[s] = rd; ls_data[s] = d;
    endtask

    task automatic bubbles();
        in_valid = '0;
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = '0; in_op = '0; in_rd = '0; in_ra = '0; in_rb = '0;
        in_va = '0; in_vb = '0; in_imm = '0; in_use_imm = '0; in_pc = '0;
        ls_valid = '0; ls_rd = '0; ls_data = '0;
        put(0, 1'b1, OP_JMP, 5'd1, 5'd0, 5'd0, 0, 0, 32'd8, 1'b0, 32'd0);
        tick(); tick(); tick();
        chk("R1 reset out_valid", {30'd0, out_valid}, 0);
        chk("R1 reset out_wen",   {30'd0, out_wen}, 0);
        chk("R1 reset br_req",    {31'd0, br_req}, 0);
        bubbles();
        rst_n = 1'b1;
        tick();

        // table walk: a bubble pair before each vector clears execute-stage bypass
        for (int k = 0; k < 13; k++) begin
            bubbles();
            tick();
            put(0, VECS[k].v0, VECS[k].op0, 5'd3, 5'd1, 5'd2, VECS[k].a0, VECS[k].b0, VECS[k].i0, VECS[k].u0, 32'd100);
            put(1, VECS[k].v1, VECS[k].op1, 5'd6, 5'd4, 5'd5, VECS[k].a1, VECS[k].b1, VECS[k].i1, VECS[k].u1, 32'd101);
            tick();
            $display("vector %0d (R2 R3 R4 R5 R9 R10 R11)", k);
            chk("R5 R9 valid slot0", {31'd0, out_valid[0]}, {31'd0, VECS[k].ev0});
            chk("R4 R11 wen slot0",  {31'd0, out_wen[0]},   {31'd0, VECS[k].ew0});
            chk("R5 R9 valid slot1", {31'd0, out_valid[1]}, {31'd0, VECS[k].ev1});
            chk("R4 R11 wen slot1",  {31'd0, out_wen[1]},   {31'd0, VECS[k].ew1});
            chk("R4 R10 br_req",     {31'd0, br_req},       {31'd0, VECS[k].ebr});
            if (VECS[k].ebr) chk("R4 R9 R10 br_target", br_target, VECS[k].etgt);
            if (VECS[k].ew0) begin
                chk("R2 R3 data slot0", out_data[0], VECS[k].ed0);
                chk("R2 rd slot0", {27'd0, out_rd[0]}, 32'd3);
            end
            if (VECS[k].ew1) chk("R2 R3 data slot1", out_data[1], VECS[k].ed1);
        end

        // R6 R7: both slots write r3, then r3 read while load-store also offers r3
        bubbles(); tick();
        put(0, 1'b1, OP_ADD, 5'd3, 5'd1, 5'd2, 32'd1, 32'd2, 0, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd3, 5'd4, 5'd5, 32'd10, 32'd20, 0, 1'b0, 0);
        tick();
        put(0, 1'b1, OP_ADD, 5'd10, 5'd3, 5'd9, 32'd1000, 32'd0, 0, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd11, 5'd8, 5'd3, 32'd1, 32'd500, 0, 1'b0, 0);
        lsw(0, 1'b1, 5'd3, 32'd777);
        tick();
        chk("R6 R7 operand A from ex slot1", out_data[0], 32'd30);
        chk("R6 operand B from ex slot1", out_data[1], 32'd31);
        lsw(0, 1'b0, 5'd0, 0);

        // R6: ex slot0 beats load-store slot1
        bubbles(); tick();
        put(0, 1'b1, OP_ADD, 5'd2, 5'd1, 5'd1, 32'd4, 32'd5, 0, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd7, 5'd1, 5'd1, 32'd1, 32'd1, 0, 1'b0, 0);
        tick();
        put(0, 1'b0, OP_ADD, 5'd0, 5'd0, 5'd0, 0, 0, 0, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd12, 5'd2, 5'd13, 32'd0, 32'd0, 0, 1'b0, 0);
        lsw(1, 1'b1, 5'd2, 32'd123);
        tick();
        chk("R6 ex slot0 over ls", out_data[1], 32'd9);
        chk("R5 bubble slot0 valid", {31'd0, out_valid[0]}, 0);

        // R7 R8: both load-store records name r5
        bubbles(); tick();
        put(0, 1'b1, OP_ADD, 5'd14, 5'd5, 5'd15, 32'd0, 32'd0, 0, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd16, 5'd17, 5'd6, 32'd1, 32'd2, 0, 1'b0, 0);
        lsw(0, 1'b1, 5'd5, 32'd50);
        lsw(1, 1'b1, 5'd5, 32'd60);
        tick();
        chk("R7 R8 ls slot1 over slot0", out_data[0], 32'd60);
        chk("R8 no match uses rf", out_data[1], 32'd3);

        // R8: invalid load-store records ignored
        put(0, 1'b1, OP_ADD, 5'd14, 5'd5, 5'd15, 32'd4, 32'd0, 0, 1'b0, 0);
        put(1, 1'b0, OP_ADD, 5'd0, 5'd0, 5'd0, 0, 0, 0, 1'b0, 0);
        lsw(0, 1'b0, 5'd5, 32'd50);
        lsw(1, 1'b0, 5'd5, 32'd99);
        tick();
        chk("R8 ls_valid low ignored", out_data[0], 32'd4);

        // R9: cancelled slot1 result is not forwarded
        put(0, 1'b1, OP_JMP, 5'd0, 5'd0, 5'd0, 0, 0, 32'd4, 1'b0, 32'd200);
        put(1, 1'b1, OP_ADD, 5'd4, 5'd1, 5'd1, 32'd50, 32'd5, 0, 1'b0, 32'd201);
        tick();
        chk("R9 jump target", br_target, 32'd204);
        chk("R9 slot1 cancelled", {31'd0, out_valid[1]}, 0);
        put(0, 1'b1, OP_ADD, 5'd18, 5'd4, 5'd19, 32'd1, 32'd0, 0, 1'b0, 0);
        put(1, 1'b0, OP_ADD, 5'd0, 5'd0, 5'd0, 0, 0, 0, 1'b0, 0);
        tick();
        chk("R9 cancelled not forwarded", out_data[0], 32'd1);
        chk("R4 no branch no redirect", {31'd0, br_req}, 0);

        // R1: reset after activity
        put(0, 1'b1, OP_JMP, 5'd1, 5'd0, 5'd0, 0, 0, 32'd4, 1'b0, 0);
        put(1, 1'b1, OP_ADD, 5'd2, 5'd0, 5'd0, 0, 0, 0, 1'b0, 0);
        rst_n = 1'b0;
        tick();
        chk("R1 mid reset valid", {30'd0, out_valid}, 0);
        chk("R1 mid reset br_req", {31'd0, br_req}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule